// File: doc/BRIEF.md
# Fourth-Order Sinc Decimate-by-Eight Filter

This block is the first rate-reduction stage behind an oversampled modulator. It receives 4-bit two's-complement samples at sixty-four times the audio rate. It filters them with a fourth-order sin(x)/x response and emits one 16-bit result for every eight samples it accepts, so results leave at eight times the audio rate. The results go on to a cascade of three half-band halving stages, which brings the overall rate reduction to 64.

The filter is built as four running-sum (integrator) stages that operate at the input rate, followed by four first-difference (comb) stages that operate at the output rate. Every internal register is 16 bits wide and wraps modulo 2^16. Because of this, the integrators may overflow freely while the comb differences still give the exact result.

Both sides use valid/ready handshakes. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is delivered on an edge where `out_valid` and `out_ready` are both high. While a result is waiting and the consumer holds `out_ready` low, the block holds that result steady and drops `in_ready`. This freezes the whole filter, so no sample and no result is lost.

Top module: `cic4_decim8`

## Requirements
- R1: While and after the asynchronous active-low reset, and before any sample is accepted, `out_valid` is low, `out_data` is zero and `in_ready` is high. The reset clears all integrator, comb and phase registers.
- R2: A result becomes valid on the clock edge that accepts the 8th, 16th, 24th, … sample counted from reset, and at no other edge. When `out_ready` is held high, `out_valid` is a one-cycle pulse.
- R3: The m-th result (m = 0, 1, …) equals the sum over k = 0..28 of h[k]·x[8m+7−k]. Here x[n] is the n-th accepted sample, taken as 4-bit two's complement and as zero before reset. h[k] are the coefficients of (1 + z^-1 + … + z^-7)^4. The result is presented as 16-bit two's complement.
- R4: A constant input x gives 4096·x from the fourth result onward. This includes −32768 for x = −8 and 28672 for x = 7.
- R5: A clock edge that accepts no sample changes no filter state. The result sequence depends only on the accepted samples, whatever idle gaps lie between them. A valid result that is taken while no new one is due leaves `out_valid` low on the next cycle.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` is still high and `out_data` is unchanged.
- R7: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R8: Overflow of the 16-bit integrators has no effect on the results. R3 holds over arbitrarily long runs, including long runs of the extreme input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 4 | Input sample, two's complement |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Filtered result, two's complement |

## Verification
The bench sweeps every constant input level and places a unit impulse, of both signs, at every one of the eight phases. This exposes a wrong tap shape, a decimation phase that is off by one sample, and a DC gain that is not 4096. Long runs of full-scale and pseudo-random samples make the integrators overflow many times. A design whose integrator or comb widths are wrong, or that saturates instead of wrapping, would then give results that drift away from the model. Random input gaps combined with random consumer stalls catch two further faults. A filter that advances on idle cycles would shift its phase. A stall that is not propagated would drop results or change them while they are held.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int unsigned SAMPLE_W_DEF   = 4;
  localparam int unsigned STAGES_DEF     = 4;
  localparam int unsigned RATIO_LOG2_DEF = 3;

  function automatic int unsigned acc_width(int unsigned sample_w,
                                            int unsigned stages,
                                            int unsigned ratio_log2);
    return sample_w + stages * ratio_log2;
  endfunction

  typedef enum logic {
    OUT_EMPTY = 1'b0,
    OUT_FULL  = 1'b1
  } out_state_e;

endpackage

// File: rtl/cic_phase_counter.sv
module cic_phase_counter #(
  parameter int unsigned RATIO_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic at_last
);

  logic [RATIO_LOG2-1:0] phase_q;

  assign at_last = (phase_q == {RATIO_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
  parameter int unsigned SAMPLE_W = 4,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned STAGES   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [ACC_W-1:0]    dout
);

  localparam int unsigned EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] acc_q   [STAGES];
  logic signed [ACC_W-1:0] partial [STAGES+1];

  assign partial[0] = {{EXT_W{din[SAMPLE_W-1]}}, din};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign partial[g+1] = acc_q[g] + partial[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g] <= '0;
      end else if (en) begin
        acc_q[g] <= partial[g+1];
      end
    end
  end

  assign dout = partial[STAGES];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);

  logic signed [ACC_W-1:0] dly_q [STAGES];
  logic signed [ACC_W-1:0] diff  [STAGES+1];

  assign diff[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q[g] <= '0;
      end else if (en) begin
        dly_q[g] <= diff[g];
      end
    end
  end

  assign dout = diff[STAGES];

endmodule

// File: rtl/cic4_decim8.sv
module cic4_decim8 #(
  parameter int unsigned SAMPLE_W   = cic_pkg::SAMPLE_W_DEF,
  parameter int unsigned STAGES     = cic_pkg::STAGES_DEF,
  parameter int unsigned RATIO_LOG2 = cic_pkg::RATIO_LOG2_DEF,
  localparam int unsigned ACC_W     = cic_pkg::acc_width(SAMPLE_W, STAGES, RATIO_LOG2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ACC_W-1:0]    out_data
);

  import cic_pkg::*;

  out_state_e              state_q;
  logic                    take;
  logic                    phase_end;
  logic                    dump;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;
  logic [ACC_W-1:0]        hold_q;

  assign in_ready = (state_q == OUT_EMPTY) || out_ready;
  assign take     = in_valid && in_ready;
  assign dump     = take && phase_end;

  cic_phase_counter #(
    .RATIO_LOG2(RATIO_LOG2)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(take),
    .at_last(phase_end)
  );

  cic_integrator_chain #(
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .STAGES  (STAGES)
  ) u_integ (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (take),
    .din  ($signed(in_data)),
    .dout (integ_out)
  );

  cic_comb_chain #(
    .ACC_W (ACC_W),
    .STAGES(STAGES)
  ) u_comb (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (dump),
    .din  (integ_out),
    .dout (comb_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OUT_EMPTY;
      hold_q  <= '0;
    end else if (dump) begin
      state_q <= OUT_FULL;
      hold_q  <= comb_out;
    end else if (out_ready) begin
      state_q <= OUT_EMPTY;
    end
  end

  assign out_valid = (state_q == OUT_FULL);
  assign out_data  = hold_q;

endmodule

// File: rtl/cic4_decim8_checker.sv
module cic4_decim8_checker #(
  parameter int unsigned RATIO_LOG2 = 3,
  parameter int unsigned ACC_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);

  logic [RATIO_LOG2-1:0] seen_q;
  logic                  took;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (took) seen_q <= seen_q + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!out_valid && out_data == '0)); // R1

  AST_STROBE_ON_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
    (took && seen_q == {RATIO_LOG2{1'b1}}) |=> out_valid); // R2

  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (took && seen_q != {RATIO_LOG2{1'b1}} && (!out_valid || out_ready)) |=> !out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!took && out_valid && out_ready) |=> !out_valid); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_FREE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R7

endmodule

bind cic4_decim8 cic4_decim8_checker #(
  .RATIO_LOG2(RATIO_LOG2),
  .ACC_W     (ACC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/cic4_decim8_bench.sv
module cic4_decim8_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  cic4_decim8 u_cic4_decim8 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int taps [29];
  int hist [4096];
  int n_acc;
  int n_out;
  int expq [$];
  bit hold_pending;
  logic [15:0] hold_val;
  bit dc_mode;
  int dc_level;
  int unsigned lcg = 32'h1234_5678;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_out(int last);
    int s = 0;
    for (int k = 0; k < 29; k++)
      if (last - k >= 0) s += taps[k] * hist[last - k];
    return s;
  endfunction

  function automatic int unsigned next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    n_acc = 0; n_out = 0; expq.delete(); hold_pending = 1'b0; dc_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 16'd0, "R1 out_data", int'(out_data), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);
    @(negedge clk);
  endtask

  // one cycle; called at a falling edge
  task automatic step(bit v, int d, bit rdy, string tag);
    int exp;
    in_valid = v; in_data = 4'(d); out_ready = rdy;
    #1;
    if (hold_pending) begin
      check(out_valid && out_data == hold_val, "R6 held result", $signed(out_data), $signed(hold_val));
      hold_pending = 1'b0;
    end
    if (!out_valid) check(in_ready, "R7 ready while empty", int'(in_ready), 1);
    if (out_valid && !out_ready) begin
      check(!in_ready, "R6 input blocked", int'(in_ready), 0);
      hold_pending = 1'b1;
      hold_val = out_data;
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected result", $signed(out_data), 0);
      end else begin
        exp = expq.pop_front();
        check($signed(out_data) == exp, tag, $signed(out_data), exp);
        if (dc_mode && n_out >= 3)
          check($signed(out_data) == 4096 * dc_level, "R4 dc gain", $signed(out_data), 4096 * dc_level);
        n_out++;
      end
    end
    if (in_valid && in_ready) begin
      hist[n_acc] = $signed(4'(d));
      n_acc++;
      if (n_acc % 8 == 0) expq.push_back(model_out(n_acc - 1));
    end
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    repeat (4) step(1'b0, 0, 1'b1, tag);
    check(expq.size() == 0, "R2 result count", expq.size(), 0);
    check(n_out == n_acc / 8, "R2 one result per eight", n_out, n_acc / 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int poly [29];
    int tmp [29];
    for (int i = 0; i < 29; i++) poly[i] = 0;
    poly[0] = 1;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 29; i++) begin
        tmp[i] = 0;
        for (int j = 0; j < 8; j++) if (i - j >= 0) tmp[i] += poly[i - j];
      end
      for (int i = 0; i < 29; i++) poly[i] = tmp[i];
    end
    for (int i = 0; i < 29; i++) taps[i] = poly[i];

    // R4: every constant level, ready held high
    for (int x = -8; x < 8; x++) begin
      do_reset();
      dc_mode = 1'b1; dc_level = x;
      for (int n = 0; n < 48; n++) step(1'b1, x, 1'b1, "R3 constant");
      drain("R3 constant");
    end

    // R3: impulses of both signs at every phase
    for (int p = 0; p < 8; p++) begin
      for (int sgn = 0; sgn < 2; sgn++) begin
        do_reset();
        for (int n = 0; n < 40; n++)
          step(1'b1, (n == p) ? (sgn ? -8 : 1) : 0, 1'b1, "R3 impulse");
        drain("R3 impulse");
      end
    end

    // R8: long full-scale runs wrap the integrators many times
    do_reset();
    dc_mode = 1'b1; dc_level = 7;
    for (int n = 0; n < 1200; n++) step(1'b1, 7, 1'b1, "R8 long positive");
    drain("R8 long positive");
    do_reset();
    dc_mode = 1'b1; dc_level = -8;
    for (int n = 0; n < 1200; n++) step(1'b1, -8, 1'b1, "R8 long negative");
    drain("R8 long negative");

    // R5/R6: random data, random gaps, random stalls
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = next_rand();
      step(r[3], int'($signed(r[7:4])), (r[10:9] != 2'b00), "R5 gapped stream");
    end
    drain("R5 gapped stream");

    // R8: random full-range stream, never stalled
    do_reset();
    for (int n = 0; n < 2000; n++) begin
      int unsigned r = next_rand();
      step(1'b1, int'($signed(r[5:2])), 1'b1, "R8 random stream");
    end
    drain("R8 random stream");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule